// File: doc/BRIEF.md
# Mode-Change and Calibration Sequencer

This block guards the configuration registers of an audio codec's control port. A control word arrives on the write port. It carries a window-enable flag, a register address and a data byte. Three registers are protected: the format register, which holds the clock select fields; the calibration-request bit of the interface register; and the miscellaneous register. They take a write only while the window flag in that same word is set. When the flag is clear, a write to them is dropped without notice and the stored value stays as it was.

Every control word copies its flag into the window state. When a word closes an open window, the sequencer raises a calibration-busy status and mutes the outputs. Both are held for a number of sample ticks. That number is long when the calibration-request bit is set at the moment of closing and short when it is clear. When an accepted format write changes the clock fields, the next frame-end strobe raises an init status and stops frame syncs. The blackout lasts a timeout counted in bit-clock ticks. The first blackout after reset uses one length and every later blackout uses another.

Top module: `mcal_seq`

## Requirements
- R1: After reset, the outputs are: window state 0, format 0x00, miscellaneous 0x00, calibration request 0, busy 0, mute 0, init 0 and frame-sync enable 1.
- R2: Every control word (wr_en high) sets the window state to its wr_mce bit. A word with wr_mce=1 writes its data into a protected register, and the new value shows one cycle later. The protected registers are: format at address 0x8; the calibration request, which is bit 3 of the data at address 0x9; and miscellaneous at address 0xC.
- R3: A word with wr_mce=0 leaves all protected registers unchanged. This includes the word that closes the window.
- R4: A word with wr_mce=0 that arrives while the window state is 1 sets busy and mute to 1 in the following cycle.
- R5: If the calibration request is 1 when the window closes, busy and mute stay high through 383 sample ticks and clear on the 384th.
- R6: If the calibration request is 0 when the window closes, busy and mute clear on the 128th sample tick.
- R7: Accepted values appear on the outputs while the window is still open. The window does not have to be closed first.
- R8: An accepted format write that changes data bits [3:0] (the clock fields) arms a clock change. Init rises and frame-sync enable falls in the cycle after the next frame_end. Bit ticks that arrive before that frame_end have no effect.
- R9: The first blackout after reset lasts 200 bit ticks and each later one lasts 60. On the last of those ticks, init clears and frame-sync enable returns to 1.
- R10: A format write that leaves bits [3:0] the same does not start a blackout.
- R11: Closing the window again while busy restarts the count. The new length is chosen by the calibration request at that second close.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| wr_en | input | 1 | Control word strobe |
| wr_mce | input | 1 | Window-enable flag carried by the word |
| wr_addr | input | 4 | Register address |
| wr_data | input | 8 | Register data |
| sample_tick | input | 1 | One pulse per sample period |
| frame_end | input | 1 | Strobe on the last sample of a frame |
| bit_tick | input | 1 | One pulse per bit clock |
| mce | output | 1 | Window state |
| fmt_reg | output | 8 | Format register |
| misc_reg | output | 8 | Miscellaneous register |
| acal | output | 1 | Calibration request bit |
| cal_busy | output | 1 | Calibration in progress |
| mute | output | 1 | Output mute |
| init_flag | output | 1 | Clock resynchronisation status |
| fsync_en | output | 1 | Frame-sync enable |

## Verification
Register contents, window state and the start of busy or blackout all show one cycle after the causing word or strobe. The bench drives each input for one cycle between falling edges and reads the outputs at the next falling edge. Busy and blackout end on the edge that takes the final counted tick. So the bench issues one tick fewer than the length and checks that the status is still high. It then issues the last tick and checks that the status has cleared, which pins each length to an exact tick count.

// File: rtl/mcal_pkg.sv
package mcal_pkg;
  localparam int unsigned ADDR_W   = 4;
  localparam int unsigned DATA_W   = 8;
  localparam int unsigned CLKF_W   = 4;
  localparam int unsigned ACAL_POS = 3;

  localparam logic [ADDR_W-1:0] A_FMT  = 4'h8;
  localparam logic [ADDR_W-1:0] A_IFC  = 4'h9;
  localparam logic [ADDR_W-1:0] A_MISC = 4'hC;

  // Clock-select fields live in the low bits of the format register.
  function automatic logic [CLKF_W-1:0] clk_fields(input logic [DATA_W-1:0] f);
    return f[CLKF_W-1:0];
  endfunction

  function automatic logic is_guarded(input logic [ADDR_W-1:0] a);
    return (a == A_FMT) || (a == A_IFC) || (a == A_MISC);
  endfunction

  // Busy length in sample ticks, chosen by the calibration request.
  function automatic int unsigned busy_len(input logic req,
                                           input int unsigned long_n,
                                           input int unsigned short_n);
    return req ? long_n : short_n;
  endfunction

  // Blackout length in bit ticks, first change after reset or later.
  function automatic int unsigned blk_len(input logic first,
                                          input int unsigned first_n,
                                          input int unsigned later_n);
    return first ? first_n : later_n;
  endfunction
endpackage

// File: rtl/mcal_regs.sv
module mcal_regs
  import mcal_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic              wr_mce,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [DATA_W-1:0] wr_data,
  output logic              mce_q,
  output logic [DATA_W-1:0] fmt_q,
  output logic [DATA_W-1:0] misc_q,
  output logic              acal_q,
  output logic              exit_evt,
  output logic              clk_chg_evt
);
  logic accept;

  // The word's own flag gates its data, so one word may open and write.
  assign accept      = wr_en && wr_mce && is_guarded(wr_addr);
  assign exit_evt    = wr_en && mce_q && !wr_mce;
  assign clk_chg_evt = accept && (wr_addr == A_FMT) &&
                       (clk_fields(wr_data) != clk_fields(fmt_q));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mce_q  <= 1'b0;
      fmt_q  <= '0;
      misc_q <= '0;
      acal_q <= 1'b0;
    end else begin
      if (wr_en) mce_q <= wr_mce;
      if (accept) begin
        unique case (wr_addr)
          A_FMT:   fmt_q  <= wr_data;
          A_MISC:  misc_q <= wr_data;
          A_IFC:   acal_q <= wr_data[ACAL_POS];
          default: ;
        endcase
      end
    end
  end
endmodule

// File: rtl/mcal_calseq.sv
module mcal_calseq
  import mcal_pkg::*;
#(
  parameter int unsigned CAL_LONG  = 384,
  parameter int unsigned CAL_SHORT = 128
) (
  input  logic clk,
  input  logic rst_n,
  input  logic exit_evt,
  input  logic acal_q,
  input  logic sample_tick,
  output logic busy_q,
  output logic mute_q
);
  localparam int unsigned MAXN = (CAL_LONG > CAL_SHORT) ? CAL_LONG : CAL_SHORT;
  localparam int unsigned CW   = $clog2(MAXN + 1);

  logic [CW-1:0] cnt_q;
  logic          last_tick;

  assign last_tick = busy_q && sample_tick && (cnt_q == CW'(1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q  <= '0;
      busy_q <= 1'b0;
      mute_q <= 1'b0;
    end else if (exit_evt) begin
      cnt_q  <= CW'(busy_len(acal_q, CAL_LONG, CAL_SHORT));
      busy_q <= 1'b1;
      mute_q <= 1'b1;
    end else if (last_tick) begin
      cnt_q  <= '0;
      busy_q <= 1'b0;
      mute_q <= 1'b0;
    end else if (busy_q && sample_tick) begin
      cnt_q  <= cnt_q - CW'(1);
    end
  end
endmodule

// File: rtl/mcal_blackout.sv
module mcal_blackout
  import mcal_pkg::*;
#(
  parameter int unsigned TO_FIRST = 200,
  parameter int unsigned TO_LATER = 60
) (
  input  logic clk,
  input  logic rst_n,
  input  logic clk_chg_evt,
  input  logic frame_end,
  input  logic bit_tick,
  output logic init_q,
  output logic fsync_en_q
);
  localparam int unsigned MAXT = (TO_FIRST > TO_LATER) ? TO_FIRST : TO_LATER;
  localparam int unsigned TW   = $clog2(MAXT + 1);

  logic [TW-1:0] cnt_q;
  logic          pend_q;
  logic          seen_q;
  logic          start_evt;
  logic          done_evt;

  assign start_evt = pend_q && frame_end && !init_q;
  assign done_evt  = init_q && bit_tick && (cnt_q == TW'(1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pend_q     <= 1'b0;
      seen_q     <= 1'b0;
      cnt_q      <= '0;
      init_q     <= 1'b0;
      fsync_en_q <= 1'b1;
    end else begin
      pend_q <= clk_chg_evt || (pend_q && !start_evt);
      if (start_evt) begin
        cnt_q      <= TW'(blk_len(!seen_q, TO_FIRST, TO_LATER));
        seen_q     <= 1'b1;
        init_q     <= 1'b1;
        fsync_en_q <= 1'b0;
      end else if (done_evt) begin
        cnt_q      <= '0;
        init_q     <= 1'b0;
        fsync_en_q <= 1'b1;
      end else if (init_q && bit_tick) begin
        cnt_q      <= cnt_q - TW'(1);
      end
    end
  end
endmodule

// File: rtl/mcal_seq.sv
module mcal_seq
  import mcal_pkg::*;
#(
  parameter int unsigned CAL_LONG  = 384,
  parameter int unsigned CAL_SHORT = 128,
  parameter int unsigned TO_FIRST  = 200,
  parameter int unsigned TO_LATER  = 60
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        wr_en,
  input  logic        wr_mce,
  input  logic [3:0]  wr_addr,
  input  logic [7:0]  wr_data,
  input  logic        sample_tick,
  input  logic        frame_end,
  input  logic        bit_tick,
  output logic        mce,
  output logic [7:0]  fmt_reg,
  output logic [7:0]  misc_reg,
  output logic        acal,
  output logic        cal_busy,
  output logic        mute,
  output logic        init_flag,
  output logic        fsync_en
);
  logic exit_evt;
  logic clk_chg_evt;

  mcal_regs u_regs (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_mce(wr_mce),
    .wr_addr(wr_addr), .wr_data(wr_data), .mce_q(mce), .fmt_q(fmt_reg),
    .misc_q(misc_reg), .acal_q(acal), .exit_evt(exit_evt),
    .clk_chg_evt(clk_chg_evt)
  );

  mcal_calseq #(.CAL_LONG(CAL_LONG), .CAL_SHORT(CAL_SHORT)) u_cal (
    .clk(clk), .rst_n(rst_n), .exit_evt(exit_evt), .acal_q(acal),
    .sample_tick(sample_tick), .busy_q(cal_busy), .mute_q(mute)
  );

  mcal_blackout #(.TO_FIRST(TO_FIRST), .TO_LATER(TO_LATER)) u_blk (
    .clk(clk), .rst_n(rst_n), .clk_chg_evt(clk_chg_evt),
    .frame_end(frame_end), .bit_tick(bit_tick),
    .init_q(init_flag), .fsync_en_q(fsync_en)
  );
endmodule

// File: rtl/mcal_seq_chk.sv
module mcal_seq_chk #(
  parameter int unsigned CAL_LONG = 384
) (
  input logic       clk,
  input logic       rst_n,
  input logic       wr_en,
  input logic       wr_mce,
  input logic [3:0] wr_addr,
  input logic       sample_tick,
  input logic       frame_end,
  input logic       bit_tick,
  input logic       mce,
  input logic [7:0] fmt_reg,
  input logic [7:0] misc_reg,
  input logic       cal_busy,
  input logic       fsync_en,
  input logic       exit_evt
);
  logic [15:0] win_cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) win_cnt <= '0;
    else if (exit_evt) win_cnt <= '0;
    else if (cal_busy && sample_tick) win_cnt <= win_cnt + 16'd1;
  end

  AST_CLOSED_FMT_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && !wr_mce && wr_addr == 4'h8) |=> $stable(fmt_reg)); // R3
  AST_CLOSED_MISC_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && !wr_mce && wr_addr == 4'hC) |=> $stable(misc_reg)); // R3
  AST_WINDOW_FOLLOWS_WORD: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |=> (mce == $past(wr_mce))); // R2
  AST_BUSY_ON_CLOSE: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && mce && !wr_mce) |=> cal_busy); // R4
  AST_BUSY_ENDS_ON_TICK: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(cal_busy) |-> $past(sample_tick)); // R5
  AST_BUSY_BOUNDED: assert property (@(posedge clk) disable iff (!rst_n)
    cal_busy |-> (win_cnt < 16'(CAL_LONG))); // R5
  AST_BLACKOUT_AT_FRAME: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(fsync_en) |-> $past(frame_end)); // R8
  AST_RESUME_ON_BIT: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(fsync_en) |-> $past(bit_tick)); // R9
endmodule

bind mcal_seq mcal_seq_chk #(.CAL_LONG(CAL_LONG)) u_chk (
  .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_mce(wr_mce),
  .wr_addr(wr_addr), .sample_tick(sample_tick), .frame_end(frame_end),
  .bit_tick(bit_tick), .mce(mce), .fmt_reg(fmt_reg), .misc_reg(misc_reg),
  .cal_busy(cal_busy), .fsync_en(fsync_en), .exit_evt(exit_evt)
);

// File: tb/test_mcal_seq.sv
module test_mcal_seq;
  localparam int unsigned CAL_LONG  = 384;
  localparam int unsigned CAL_SHORT = 128;
  localparam int unsigned TO_FIRST  = 200;
  localparam int unsigned TO_LATER  = 60;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic wr_en = 1'b0, wr_mce = 1'b0;
  logic [3:0] wr_addr = '0;
  logic [7:0] wr_data = '0;
  logic sample_tick = 1'b0, frame_end = 1'b0, bit_tick = 1'b0;
  logic mce, acal, cal_busy, mute, init_flag, fsync_en;
  logic [7:0] fmt_reg, misc_reg;

  int n_chk = 0;
  int n_bad = 0;
  bit finished = 1'b0;

  always #10 clk = ~clk;

  mcal_seq #(.CAL_LONG(CAL_LONG), .CAL_SHORT(CAL_SHORT),
             .TO_FIRST(TO_FIRST), .TO_LATER(TO_LATER)) i_mcal_seq (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_mce(wr_mce),
    .wr_addr(wr_addr), .wr_data(wr_data), .sample_tick(sample_tick),
    .frame_end(frame_end), .bit_tick(bit_tick), .mce(mce),
    .fmt_reg(fmt_reg), .misc_reg(misc_reg), .acal(acal),
    .cal_busy(cal_busy), .mute(mute), .init_flag(init_flag),
    .fsync_en(fsync_en)
  );

  // Vector: {mce, addr, data, exp_mce, exp_fmt, exp_misc, exp_acal}
  localparam int NV = 8;
  localparam logic [30:0] VEC [NV] = '{
    {1'b0, 4'h8, 8'h55, 1'b0, 8'h00, 8'h00, 1'b0},  // R3 closed fmt
    {1'b0, 4'hC, 8'hAA, 1'b0, 8'h00, 8'h00, 1'b0},  // R3 closed misc
    {1'b1, 4'h8, 8'h50, 1'b1, 8'h50, 8'h00, 1'b0},  // R2 open+write same word
    {1'b1, 4'hC, 8'h3C, 1'b1, 8'h50, 8'h3C, 1'b0},  // R7
    {1'b1, 4'h9, 8'h08, 1'b1, 8'h50, 8'h3C, 1'b1},  // R2 acal bit 3
    {1'b1, 4'h9, 8'h00, 1'b1, 8'h50, 8'h3C, 1'b0},
    {1'b1, 4'h9, 8'hF8, 1'b1, 8'h50, 8'h3C, 1'b1},
    {1'b0, 4'hC, 8'h11, 1'b0, 8'h50, 8'h3C, 1'b1}   // R3 closing word dropped
  };

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic put_word(input logic m, input logic [3:0] a, input logic [7:0] d);
    @(negedge clk);
    wr_en = 1'b1; wr_mce = m; wr_addr = a; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic stick(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk); sample_tick = 1'b1;
      @(negedge clk); sample_tick = 1'b0;
    end
  endtask

  task automatic btick(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk); bit_tick = 1'b1;
      @(negedge clk); bit_tick = 1'b0;
    end
  endtask

  task automatic fend();
    @(negedge clk); frame_end = 1'b1;
    @(negedge clk); frame_end = 1'b0;
  endtask

  task automatic summary();
    if (!finished) begin
      finished = 1'b1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_chk++; n_bad++;
    $display("FAIL watchdog: actual=running expected=done");
    summary();
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    check("R1 mce", mce, 0);       check("R1 fmt", fmt_reg, 0);
    check("R1 misc", misc_reg, 0); check("R1 acal", acal, 0);
    check("R1 busy", cal_busy, 0); check("R1 mute", mute, 0);
    check("R1 init", init_flag, 0); check("R1 fsync", fsync_en, 1);

    for (int v = 0; v < NV; v++) begin
      put_word(VEC[v][30], VEC[v][29:26], VEC[v][25:18]);
      check("R2 mce", mce, VEC[v][17]);
      check("R2/R3 fmt", fmt_reg, VEC[v][16:9]);
      check("R2/R3 misc", misc_reg, VEC[v][8:1]);
      check("R2/R3 acal", acal, VEC[v][0]);
      check("R10 fsync", fsync_en, 1);
    end

    // Last vector closed the window with acal=1: long busy
    check("R4 busy", cal_busy, 1); check("R4 mute", mute, 1);
    stick(CAL_LONG - 1);
    check("R5 busy before end", cal_busy, 1);
    stick(1);
    check("R5 busy cleared", cal_busy, 0); check("R5 mute cleared", mute, 0);

    // Short calibration
    put_word(1'b1, 4'h9, 8'h00);
    check("R7 acal while open", acal, 0);
    check("R4 no busy while open", cal_busy, 0);
    put_word(1'b0, 4'h0, 8'h00);
    check("R4 busy short", cal_busy, 1);
    stick(CAL_SHORT - 1);
    check("R6 busy before end", cal_busy, 1);
    stick(1);
    check("R6 busy cleared", cal_busy, 0); check("R6 mute cleared", mute, 0);

    // R11 restart with the request at the second close
    put_word(1'b1, 4'h9, 8'h08);
    put_word(1'b0, 4'h0, 8'h00);
    stick(10);
    put_word(1'b1, 4'h9, 8'h00);
    put_word(1'b0, 4'h0, 8'h00);
    stick(CAL_SHORT - 1);
    check("R11 busy before end", cal_busy, 1);
    stick(1);
    check("R11 busy cleared", cal_busy, 0);

    // First clock change
    put_word(1'b1, 4'h8, 8'h53);
    check("R8 no init yet", init_flag, 0);
    btick(5);
    check("R8 fsync before frame", fsync_en, 1);
    fend();
    check("R8 init", init_flag, 1); check("R8 fsync off", fsync_en, 0);
    btick(TO_FIRST - 1);
    check("R9 first still init", init_flag, 1);
    btick(1);
    check("R9 first init cleared", init_flag, 0);
    check("R9 first fsync back", fsync_en, 1);

    // Later clock change
    put_word(1'b1, 4'h8, 8'h57);
    fend();
    check("R8 init second", init_flag, 1);
    btick(TO_LATER - 1);
    check("R9 later still init", init_flag, 1);
    btick(1);
    check("R9 later init cleared", init_flag, 0);
    check("R9 later fsync back", fsync_en, 1);

    // Same clock fields: no blackout
    put_word(1'b1, 4'h8, 8'hF7);
    check("R10 fmt written", fmt_reg, 8'hF7);
    fend();
    check("R10 no init", init_flag, 0); check("R10 fsync kept", fsync_en, 1);

    put_word(1'b0, 4'h0, 8'h00);
    repeat (2) @(negedge clk);
    summary();
  end
endmodule